// File: doc/BRIEF.md
# Configurable ADC Output Frame Assembler

This block turns one conversion result into a serial output frame and sends it MSB first on a single data line. A control word selects which optional fields follow the data: the device address, the supply alarm flags, the input alarm flags and the input range code. It can also append two even-parity bits, and it can replace the conversion data with one of four fixed test patterns. Because of these options the frame is between 16 and 30 bits long.

A one-cycle `start` pulse captures the conversion word, the address, the range code, the four alarm flags and the control word. From the next cycle the frame goes out one bit per clock while `frame_active` is high. `frame_len` reports the length of the frame being sent and does not change until the frame ends. The register bus, the analog path and the alarm threshold logic are outside this block.

Top module: `adc_frame_tx`

## Requirements
- R1: With control bits [9:3] at 0 and a payload select below 4, a frame is the 16-bit conversion word sent MSB first, and `frame_len` is 16.
- R2: `ctrl[2:0]` selects the payload. Values 0 to 3 send the conversion word. 4 sends all zeros, 5 all ones, 6 alternating bits starting 1010, and 7 alternating pairs starting 1100.
- R3: When `ctrl[9]` is 1, the 4-bit device address is appended MSB first and the frame grows by 4 bits.
- R4: `ctrl[6:5]` controls the input alarm flags. 01 appends the high flag, 10 appends the low flag, 11 appends the high flag and then the low flag, and 00 appends nothing.
- R5: `ctrl[8:7]` controls the supply alarm flags, using the same encoding and order as R4.
- R6: When `ctrl[4]` is 1, the 4-bit range code is appended MSB first and the frame grows by 4 bits.
- R7: Fields always appear in this order: payload, address, supply flags, input flags, range code, data parity, frame parity.
- R8: When `ctrl[3]` is 1, two bits are appended at the end of the frame. The first is the even parity of the 16 payload bits actually sent.
- R9: The last bit is the even parity of every earlier frame bit except the data parity bit.
- R10: `ctrl[31:10]` have no effect on the frame.
- R11: Inputs are captured at the clock edge where `start` is accepted. A `start` that arrives while a frame is active is ignored. Changing the inputs during a frame has no effect on it, and `frame_len` stays constant while `frame_active` is high.
- R12: After reset, `frame_active` is 0, `sdo` is 0 and `frame_len` is 16.
- R13: The first frame bit appears in the cycle after the accepting edge. `frame_active` stays high for exactly `frame_len` cycles, and `sdo` is 0 whenever `frame_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the inputs and starts a frame |
| conv_data | input | 16 | Conversion result |
| dev_addr | input | 4 | Device address field |
| range_code | input | 4 | Input range code field |
| in_alarm_hi | input | 1 | Input alarm flag, high threshold |
| in_alarm_lo | input | 1 | Input alarm flag, low threshold |
| sup_alarm_hi | input | 1 | Supply alarm flag, high threshold |
| sup_alarm_lo | input | 1 | Supply alarm flag, low threshold |
| ctrl | input | 32 | Frame control word |
| sdo | output | 1 | Serial data, MSB first |
| frame_active | output | 1 | High while frame bits are being sent |
| frame_len | output | 5 | Length of the current frame in bits |

## Verification
`start` is sampled at a rising edge. From that edge, `frame_active`, `frame_len` and frame bit 0 are due one edge later, and bit k is due k edges after that. `frame_active` drops `frame_len` edges after it rises. The bench drives inputs at falling edges and samples at the falling edge after each of those rising edges. It compares each sample against a bit list that it builds itself from the requirements. To show that the inputs were captured, the bench scrambles them right after `start` falls. It also fires a second `start` part-way through one frame and checks that the frame is unaffected.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

   // control word field positions
   localparam int CTL_SEL_LSB  = 0;
   localparam int CTL_SEL_W    = 3;
   localparam int CTL_PAR_BIT  = 3;
   localparam int CTL_RNG_BIT  = 4;
   localparam int CTL_IN_LSB   = 5;
   localparam int CTL_SUP_LSB  = 7;
   localparam int CTL_ADDR_BIT = 9;
   localparam int CTL_USED_W   = 10;
   localparam int CTL_W        = 32;

   // fixed payload choices when the select MSB is set
   typedef enum logic [1:0] {
      PAT_ZEROS = 2'b00,
      PAT_ONES  = 2'b01,
      PAT_ALT1  = 2'b10,
      PAT_ALT2  = 2'b11
   } pat_e;

   // alarm flag pair and its 2-bit include mask
   typedef struct packed {
      logic hi;
      logic lo;
   } flag_pair_t;

   typedef struct packed {
      logic [1:0] sup_sel;
      logic [1:0] in_sel;
      logic       addr_en;
      logic       rng_en;
      logic       par_en;
   } frame_opts_t;

endpackage

// File: rtl/frame_payload_sel.sv
module frame_payload_sel
   import adc_frame_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [CTL_SEL_W-1:0] sel,
   input  logic [DATA_W-1:0]    conv_data,
   output logic [DATA_W-1:0]    payload
);

   logic [DATA_W-1:0] alt1_pat;
   logic [DATA_W-1:0] alt2_pat;

   // k counts from the MSB, so both patterns open with a 1
   for (genvar i = 0; i < DATA_W; i++) begin : g_pat
      localparam int K = DATA_W - 1 - i;
      assign alt1_pat[i] = ((K % 2) == 0);
      assign alt2_pat[i] = (((K / 2) % 2) == 0);
   end

   always_comb begin
      if (!sel[CTL_SEL_W-1]) begin
         payload = conv_data;
      end else begin
         unique case (pat_e'(sel[1:0]))
            PAT_ZEROS: payload = '0;
            PAT_ONES:  payload = '1;
            PAT_ALT1:  payload = alt1_pat;
            PAT_ALT2:  payload = alt2_pat;
            default:   payload = '0;
         endcase
      end
   end

endmodule

// File: rtl/frame_builder.sv
module frame_builder
   import adc_frame_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 4,
   parameter int RANGE_W = 4,
   parameter int MAX_W   = DATA_W + ADDR_W + RANGE_W + 6,
   parameter int LEN_W   = $clog2(MAX_W + 1)
) (
   input  logic [DATA_W-1:0]  payload,
   input  logic [ADDR_W-1:0]  dev_addr,
   input  logic [RANGE_W-1:0] range_code,
   input  flag_pair_t         in_flags,
   input  flag_pair_t         sup_flags,
   input  frame_opts_t        opts,
   output logic [MAX_W-1:0]   frame_al,
   output logic [LEN_W-1:0]   frame_len
);

   logic [MAX_W-1:0] acc;
   logic [LEN_W-1:0] n;
   logic             data_par;
   logic             frame_par;

   assign data_par = ^payload;

   // fields are shifted in at the LSB end in send order,
   // then the whole frame is moved to the MSB end
   always_comb begin
      acc              = '0;
      acc[DATA_W-1:0]  = payload;
      n                = LEN_W'(DATA_W);
      frame_par        = 1'b0;
      if (opts.addr_en) begin
         acc = (acc << ADDR_W) | MAX_W'(dev_addr);
         n   = n + LEN_W'(ADDR_W);
      end
      if (opts.sup_sel[0]) begin
         acc = {acc[MAX_W-2:0], sup_flags.hi};
         n   = n + LEN_W'(1);
      end
      if (opts.sup_sel[1]) begin
         acc = {acc[MAX_W-2:0], sup_flags.lo};
         n   = n + LEN_W'(1);
      end
      if (opts.in_sel[0]) begin
         acc = {acc[MAX_W-2:0], in_flags.hi};
         n   = n + LEN_W'(1);
      end
      if (opts.in_sel[1]) begin
         acc = {acc[MAX_W-2:0], in_flags.lo};
         n   = n + LEN_W'(1);
      end
      if (opts.rng_en) begin
         acc = (acc << RANGE_W) | MAX_W'(range_code);
         n   = n + LEN_W'(RANGE_W);
      end
      if (opts.par_en) begin
         frame_par = ^acc;
         acc       = {acc[MAX_W-3:0], data_par, frame_par};
         n         = n + LEN_W'(2);
      end
      frame_al  = acc << (LEN_W'(MAX_W) - n);
      frame_len = n;
   end

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
   parameter int MAX_W   = 30,
   parameter int LEN_W   = $clog2(MAX_W + 1),
   parameter int RST_LEN = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MAX_W-1:0] frame_al,
   input  logic [LEN_W-1:0] frame_len,
   output logic             sdo,
   output logic             busy,
   output logic [LEN_W-1:0] len_q
);

   logic [MAX_W-1:0] sr;
   logic [LEN_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= '0;
         left  <= '0;
         busy  <= 1'b0;
         len_q <= LEN_W'(RST_LEN);
      end else if (load && !busy) begin
         sr    <= frame_al;
         left  <= frame_len;
         busy  <= 1'b1;
         len_q <= frame_len;
      end else if (busy) begin
         sr   <= sr << 1;
         left <= left - LEN_W'(1);
         if (left == LEN_W'(1)) begin
            busy <= 1'b0;
         end
      end
   end

   assign sdo = sr[MAX_W-1];

endmodule

// File: rtl/adc_frame_tx.sv
module adc_frame_tx
   import adc_frame_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 4,
   parameter int RANGE_W = 4,
   localparam int MAX_W  = DATA_W + ADDR_W + RANGE_W + 6,
   localparam int LEN_W  = $clog2(MAX_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DATA_W-1:0]  conv_data,
   input  logic [ADDR_W-1:0]  dev_addr,
   input  logic [RANGE_W-1:0] range_code,
   input  logic               in_alarm_hi,
   input  logic               in_alarm_lo,
   input  logic               sup_alarm_hi,
   input  logic               sup_alarm_lo,
   input  logic [CTL_W-1:0]   ctrl,
   output logic               sdo,
   output logic               frame_active,
   output logic [LEN_W-1:0]   frame_len
);

   if (DATA_W < 4) begin : g_bad_data_w
      $error("adc_frame_tx: DATA_W must be at least 4");
   end
   if (ADDR_W < 1 || RANGE_W < 1) begin : g_bad_field_w
      $error("adc_frame_tx: address and range fields need at least one bit");
   end

   frame_opts_t       opts;
   flag_pair_t        in_flags;
   flag_pair_t        sup_flags;
   logic [DATA_W-1:0] payload;
   logic [MAX_W-1:0]  frame_al;
   logic [LEN_W-1:0]  next_len;
   logic              unused_rsvd;

   assign unused_rsvd = ^ctrl[CTL_W-1:CTL_USED_W];

   assign opts.sup_sel = ctrl[CTL_SUP_LSB +: 2];
   assign opts.in_sel  = ctrl[CTL_IN_LSB +: 2];
   assign opts.addr_en = ctrl[CTL_ADDR_BIT];
   assign opts.rng_en  = ctrl[CTL_RNG_BIT];
   assign opts.par_en  = ctrl[CTL_PAR_BIT];

   assign in_flags.hi  = in_alarm_hi;
   assign in_flags.lo  = in_alarm_lo;
   assign sup_flags.hi = sup_alarm_hi;
   assign sup_flags.lo = sup_alarm_lo;

   frame_payload_sel #(.DATA_W(DATA_W)) u_pay (
      .sel       (ctrl[CTL_SEL_LSB +: CTL_SEL_W]),
      .conv_data (conv_data),
      .payload   (payload)
   );

   frame_builder #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .RANGE_W (RANGE_W),
      .MAX_W   (MAX_W),
      .LEN_W   (LEN_W)
   ) u_build (
      .payload    (payload),
      .dev_addr   (dev_addr),
      .range_code (range_code),
      .in_flags   (in_flags),
      .sup_flags  (sup_flags),
      .opts       (opts),
      .frame_al   (frame_al),
      .frame_len  (next_len)
   );

   frame_shifter #(
      .MAX_W   (MAX_W),
      .LEN_W   (LEN_W),
      .RST_LEN (DATA_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .frame_al  (frame_al),
      .frame_len (next_len),
      .sdo       (sdo),
      .busy      (frame_active),
      .len_q     (frame_len)
   );

endmodule

// File: rtl/adc_frame_tx_chk.sv
module adc_frame_tx_chk #(
   parameter int DATA_W = 16,
   parameter int MAX_W  = 30,
   parameter int LEN_W  = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [6:0]       ctrl_opts,
   input logic             sdo,
   input logic             frame_active,
   input logic [LEN_W-1:0] frame_len
);

   logic [LEN_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run_cnt <= '0;
      else if (frame_active) run_cnt <= run_cnt + LEN_W'(1);
      else                   run_cnt <= '0;
   end

   // R13
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_active |-> !sdo);

   // R13
   run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_active) |-> run_cnt == frame_len);

   // R11
   len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_active && $past(frame_active)) |-> $stable(frame_len));

   // R11
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !frame_active) |=> frame_active);

   // R1
   base_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !frame_active && ctrl_opts == 7'd0) |=> frame_len == LEN_W'(DATA_W));

   // R7
   len_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_len >= LEN_W'(DATA_W) && frame_len <= LEN_W'(MAX_W));

endmodule

bind adc_frame_tx adc_frame_tx_chk #(
   .DATA_W (DATA_W),
   .MAX_W  (MAX_W),
   .LEN_W  (LEN_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .ctrl_opts    (ctrl[9:3]),
   .sdo          (sdo),
   .frame_active (frame_active),
   .frame_len    (frame_len)
);

// File: tb/tb_adc_frame_tx.sv
`timescale 1ns/1ps
module tb_adc_frame_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] conv_data = '0;
   logic [3:0]  dev_addr = '0;
   logic [3:0]  range_code = '0;
   logic        in_alarm_hi = 1'b0;
   logic        in_alarm_lo = 1'b0;
   logic        sup_alarm_hi = 1'b0;
   logic        sup_alarm_lo = 1'b0;
   logic [31:0] ctrl = '0;
   logic        sdo;
   logic        frame_active;
   logic [4:0]  frame_len;

   int n_chk = 0;
   int n_err = 0;
   bit exp_bits [64];
   int exp_len;

   always #2.5 clk = ~clk;

   adc_frame_tx dut (
      .clk(clk), .rst_n(rst_n), .start(start), .conv_data(conv_data),
      .dev_addr(dev_addr), .range_code(range_code),
      .in_alarm_hi(in_alarm_hi), .in_alarm_lo(in_alarm_lo),
      .sup_alarm_hi(sup_alarm_hi), .sup_alarm_lo(sup_alarm_lo),
      .ctrl(ctrl), .sdo(sdo), .frame_active(frame_active), .frame_len(frame_len)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp_v);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
      end
   endtask

   task automatic push(input bit b);
      exp_bits[exp_len] = b;
      exp_len++;
   endtask

   // expected frame from the requirements
   task automatic build_exp(input logic [31:0] c, input logic [15:0] d,
                            input logic [3:0] a, input logic [3:0] r,
                            input bit ih, input bit il, input bit sh, input bit sl);
      logic [15:0] pay;
      bit fp;
      exp_len = 0;
      if (!c[2]) pay = d;
      else begin
         for (int k = 0; k < 16; k++) begin
            case (c[1:0])
               2'd0: pay[15-k] = 1'b0;
               2'd1: pay[15-k] = 1'b1;
               2'd2: pay[15-k] = ((k % 2) == 0);
               default: pay[15-k] = (((k / 2) % 2) == 0);
            endcase
         end
      end
      for (int k = 15; k >= 0; k--) push(pay[k]);
      if (c[9]) for (int k = 3; k >= 0; k--) push(a[k]);
      if (c[7]) push(sh);
      if (c[8]) push(sl);
      if (c[5]) push(ih);
      if (c[6]) push(il);
      if (c[4]) for (int k = 3; k >= 0; k--) push(r[k]);
      if (c[3]) begin
         fp = 1'b0;
         for (int k = 0; k < exp_len; k++) fp ^= exp_bits[k];
         push(^pay);
         push(fp);
      end
   endtask

   // one frame; mid_start fires a second start after bit 3
   task automatic run_frame(input string req, input logic [31:0] c,
                            input logic [15:0] d, input logic [3:0] a,
                            input logic [3:0] r, input bit ih, input bit il,
                            input bit sh, input bit sl, input bit mid_start);
      int bad;
      int first_bad;
      @(negedge clk);
      ctrl = c; conv_data = d; dev_addr = a; range_code = r;
      in_alarm_hi = ih; in_alarm_lo = il; sup_alarm_hi = sh; sup_alarm_lo = sl;
      build_exp(c, d, a, r, ih, il, sh, sl);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // scramble inputs: the frame must come from captured values (R11)
      ctrl = ~c; conv_data = ~d; dev_addr = ~a; range_code = ~r;
      in_alarm_hi = ~ih; in_alarm_lo = ~il; sup_alarm_hi = ~sh; sup_alarm_lo = ~sl;
      check(frame_active == 1'b1, "R13", {req, " active after start"}, frame_active, 1);
      check(frame_len == 5'(exp_len), req, "frame length", frame_len, exp_len);
      bad = 0;
      first_bad = -1;
      for (int k = 0; k < exp_len; k++) begin
         if (sdo !== exp_bits[k] || frame_active !== 1'b1 || frame_len !== 5'(exp_len)) begin
            bad++;
            if (first_bad < 0) first_bad = k;
         end
         if (mid_start && k == 3) start = 1'b1;
         else start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      check(bad == 0, req, {req, " frame bits, first bad index"}, first_bad, -1);
      check(frame_active == 1'b0 && sdo == 1'b0, "R13", {req, " idle after frame"},
            {frame_active, sdo}, 0);
   endtask

   task automatic t_reset;
      check(frame_active == 1'b0, "R12", "reset active", frame_active, 0);
      check(sdo == 1'b0, "R12", "reset sdo", sdo, 0);
      check(frame_len == 5'd16, "R12", "reset length", frame_len, 16);
   endtask

   task automatic t_plain;
      run_frame("R1", 32'h0, 16'hA5C3, 4'h0, 4'h0, 0, 0, 0, 0, 0);
      run_frame("R1", 32'h3, 16'h1234, 4'hF, 4'hF, 1, 1, 1, 1, 0);
   endtask

   task automatic t_patterns;
      for (int p = 4; p < 8; p++)
         run_frame("R2", 32'(p), 16'h3C69, 4'h0, 4'h0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_fields;
      run_frame("R3", 32'h200, 16'h8001, 4'hB, 4'h0, 0, 0, 0, 0, 0);
      run_frame("R4", 32'h020, 16'h0F0F, 4'h0, 4'h0, 1, 0, 0, 0, 0);
      run_frame("R4", 32'h040, 16'h0F0F, 4'h0, 4'h0, 1, 0, 0, 0, 0);
      run_frame("R4", 32'h060, 16'h0F0F, 4'h0, 4'h0, 1, 0, 0, 0, 0);
      run_frame("R5", 32'h080, 16'hF0F0, 4'h0, 4'h0, 0, 0, 0, 1, 0);
      run_frame("R5", 32'h100, 16'hF0F0, 4'h0, 4'h0, 0, 0, 0, 1, 0);
      run_frame("R5", 32'h180, 16'hF0F0, 4'h0, 4'h0, 0, 0, 1, 0, 0);
      run_frame("R6", 32'h010, 16'h0001, 4'h0, 4'h6, 0, 0, 0, 0, 0);
      run_frame("R7", 32'h3F0, 16'hBEEF, 4'h9, 4'h5, 1, 0, 0, 1, 0);
   endtask

   task automatic t_parity;
      run_frame("R8", 32'h008, 16'h0007, 4'h0, 4'h0, 0, 0, 0, 0, 0);
      run_frame("R9", 32'h3F8, 16'h1111, 4'h7, 4'h3, 1, 1, 0, 1, 0);
      run_frame("R9", 32'h3FE, 16'h0000, 4'h1, 4'h8, 0, 1, 1, 1, 0);
      run_frame("R8", 32'h00F, 16'h0000, 4'h0, 4'h0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_reserved;
      run_frame("R10", 32'hFFFF_FC00, 16'h5A5A, 4'hC, 4'hD, 1, 1, 1, 1, 0);
      run_frame("R10", 32'hA5A5_6C00 | 32'h218, 16'h5A5A, 4'hC, 4'hD, 1, 1, 1, 1, 0);
   endtask

   task automatic t_busy_start;
      run_frame("R11", 32'h218, 16'hC0DE, 4'h2, 4'h0, 0, 0, 0, 0, 1);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_patterns();
      t_fields();
      t_parity();
      t_reserved();
      t_busy_start();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule